// File: doc/BRIEF.md
# Lane drive level mapper

This block converts the per-lane adjustment requests reported by a DisplayPort sink into transmitter drive settings. A request for each active lane is a swing level and a pre-emphasis level packed into a nibble of two adjust-request bytes. The block looks each request up in a small table of drive records and returns the settings the transmitter and sink need: one training-set byte per lane, plus packed 32-bit drive, pre-emphasis and auxiliary control words, each with its write mask.

The table sits in on-chip registers outside the block and arrives as one flat vector. Record r occupies bits [r*40 +: 40]. Within a record, byte 0 is the swing level, byte 1 the pre-emphasis level, byte 2 the drive value, byte 3 the pre-emphasis value and byte 4 the auxiliary control value. A pulse on `start` latches the requests, the lane count and the record count. The block then walks the table one record per clock for lane 0, then lane 1, and so on. On success it commits all outputs at once with a one-cycle `done`. If any lane finds no matching record, it raises `err` with `done` and leaves every output word as it was.

Top module: `lane_drive_mapper`

## Requirements
- R1: After reset, every output word is zero and `busy`, `done` and `err` are low. `aux_mask` always reads 0x0000FF0F.
- R2: Lane i takes its request from `adj_lo` for lanes 0 and 1 and from `adj_hi` for lanes 2 and 3. Even lanes use bits 3:0 and odd lanes use bits 7:4. Within the nibble, bits 1:0 are the swing level and bits 3:2 are the pre-emphasis level.
- R3: The search covers records 0 to N-1, where N is `rec_num` clamped to REC_DEPTH. It runs in increasing index order and takes the first record whose byte 0 equals the requested swing and whose byte 1 equals the requested pre-emphasis. Records at index N or above are never used.
- R4: A lane's training-set byte is (pre-emphasis << 3) | swing. Bit 2 is set when swing is 3 and bit 5 is set when pre-emphasis is 3. Lane i's byte sits at `lane_set` bits [8*i +: 8].
- R5: Lanes 0, 1, 2 and 3 use bit shifts 16, 8, 0 and 24. At its shift, each active lane places its record's byte 2 into `drv_word`, its byte 3 into `emph_word`, and 0xFF into `lane_mask`.
- R6: `aux_word` bits 15:8 hold byte 4 of the record matched by the highest active lane. Bit (shift/8) within bits 3:0 is set for each active lane. All other bits are zero.
- R7: Lanes at or above the active lane count have zero training-set bytes, zero drive and pre-emphasis bytes, and clear mask bytes.
- R8: If any active lane finds no matching record, `err` rises together with `done`. No output word changes. `err` stays high until the next accepted `start`.
- R9: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until `done`. A `start` pulse or a change of request, lane-count or record-count inputs while busy has no effect on the result.
- R10: One record is examined per clock. A lane matched at index k costs k+1 cycles, and a lane that fails costs N+1 cycles. `done` is high after the clock edge whose count from the accepting edge equals the sum of these costs.
- R11: A `lane_cnt` of 0 or above 4 gives `err` with `done` at the accepting edge. No output word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a mapping operation |
| adj_lo | input | 8 | Adjust-request byte for lanes 0 and 1 |
| adj_hi | input | 8 | Adjust-request byte for lanes 2 and 3 |
| lane_cnt | input | 3 | Active lane count (1, 2 or 4; 3 also works) |
| rec_num | input | 5 | Number of valid table records |
| tbl_flat | input | REC_DEPTH*40 | Flat drive-record table |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation failed |
| lane_set | output | 32 | Training-set bytes, lane i at bits 8i+7:8i |
| drv_word | output | 32 | Packed drive values |
| emph_word | output | 32 | Packed pre-emphasis values |
| lane_mask | output | 32 | Write mask for drive and pre-emphasis words |
| aux_word | output | 32 | Auxiliary control word |
| aux_mask | output | 32 | Write mask for the auxiliary word |

## Verification
The mapping is tried with four groups of patterns.

- Single-lane and two-lane requests with different nibbles in each half of `adj_lo`. These show whether the right nibble reaches the right lane.
- A four-lane request mixing maximum and non-maximum levels. This separates the non-linear shift order from a linear one and exercises both flag bits.
- A table with a duplicated key, and a wanted record placed just past the record count. These tell a first-match search from a last-match one and show whether the count limit is honoured.
- Failing requests on a later lane, an empty table and illegal lane counts. These show that a failure commits nothing. The cycle count of every operation is compared with the per-record cost, and a second `start` issued mid-search must leave the result unchanged.

// File: rtl/lmap_pkg.sv
package lmap_pkg;

    localparam int REC_W = 40;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1
    } fsm_e;

    typedef struct packed {
        logic [7:0] sw_lvl;
        logic [7:0] pe_lvl;
        logic [7:0] drv_val;
        logic [7:0] pe_val;
        logic [7:0] aux_val;
    } rec_t;

    typedef struct packed {
        fsm_e        fsm;
        logic [1:0]  lane;
        logic [1:0]  last;
        logic [4:0]  rec;
        logic [4:0]  nrec;
        logic [15:0] adj;
        logic [31:0] w_set;
        logic [31:0] w_drv;
        logic [31:0] w_emph;
        logic [31:0] w_mask;
        logic [7:0]  w_auxv;
        logic [3:0]  w_en;
        logic [31:0] o_set;
        logic [31:0] o_drv;
        logic [31:0] o_emph;
        logic [31:0] o_mask;
        logic [31:0] o_aux;
        logic        done;
        logic        err;
    } state_t;

    // Register byte placement per lane: non-linear order
    function automatic logic [4:0] lane_shift(input logic [1:0] lane);
        case (lane)
            2'd0:    return 5'd16;
            2'd1:    return 5'd8;
            2'd2:    return 5'd0;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/lmap_nib_pick.sv
module lmap_nib_pick (
    input  logic [15:0] adj,
    input  logic [1:0]  lane,
    output logic [1:0]  sw,
    output logic [1:0]  pe
);
    logic [7:0] byte_sel;
    logic [3:0] nib;

    always_comb begin
        byte_sel = lane[1] ? adj[15:8] : adj[7:0];
        nib      = lane[0] ? byte_sel[7:4] : byte_sel[3:0];
        sw       = nib[1:0];
        pe       = nib[3:2];
    end
endmodule

// File: rtl/lmap_rec_pick.sv
module lmap_rec_pick
    import lmap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH*REC_W-1:0] tbl,
    input  logic [4:0]             idx,
    output rec_t                   rec
);
    rec_t arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign arr[g] = {tbl[g*REC_W +  0 +: 8],
                         tbl[g*REC_W +  8 +: 8],
                         tbl[g*REC_W + 16 +: 8],
                         tbl[g*REC_W + 24 +: 8],
                         tbl[g*REC_W + 32 +: 8]};
    end

    always_comb begin
        rec = '0;
        for (int r = 0; r < DEPTH; r++) begin
            if (idx == 5'(r)) rec = arr[r];
        end
    end
endmodule

// File: rtl/lmap_lane_pack.sv
module lmap_lane_pack
    import lmap_pkg::*;
(
    input  logic [1:0]  lane,
    input  logic [1:0]  sw,
    input  logic [1:0]  pe,
    input  logic [7:0]  drv_val,
    input  logic [7:0]  pe_val,
    output logic [7:0]  set_byte,
    output logic [31:0] drv_part,
    output logic [31:0] emph_part,
    output logic [31:0] mask_part,
    output logic [3:0]  en_part
);
    logic [4:0] sh;

    always_comb begin
        sh        = lane_shift(lane);
        set_byte  = {2'b00, (pe == 2'd3), pe, (sw == 2'd3), sw};
        drv_part  = {24'd0, drv_val} << sh;
        emph_part = {24'd0, pe_val} << sh;
        mask_part = 32'h0000_00FF << sh;
        en_part   = 4'b0001 << sh[4:3];
    end
endmodule

// File: rtl/lane_drive_mapper.sv
module lane_drive_mapper
    import lmap_pkg::*;
#(
    parameter int REC_DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [7:0]                 adj_lo,
    input  logic [7:0]                 adj_hi,
    input  logic [2:0]                 lane_cnt,
    input  logic [4:0]                 rec_num,
    input  logic [REC_DEPTH*REC_W-1:0] tbl_flat,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [31:0]                lane_set,
    output logic [31:0]                drv_word,
    output logic [31:0]                emph_word,
    output logic [31:0]                lane_mask,
    output logic [31:0]                aux_word,
    output logic [31:0]                aux_mask
);
    localparam logic [4:0]  DEPTH_L  = 5'(REC_DEPTH);
    localparam logic [31:0] AUX_MSK  = 32'h0000_FF0F;

    state_t s_d, s_q;

    logic [1:0]  nib_sw, nib_pe;
    rec_t        cur_rec;
    logic [7:0]  pk_set;
    logic [31:0] pk_drv, pk_emph, pk_mask;
    logic [3:0]  pk_en;
    logic        hit;
    logic [31:0] nx_set, nx_drv, nx_emph, nx_mask;
    logic [3:0]  nx_en;

    lmap_nib_pick i_nib (
        .adj  (s_q.adj),
        .lane (s_q.lane),
        .sw   (nib_sw),
        .pe   (nib_pe)
    );

    lmap_rec_pick #(.DEPTH(REC_DEPTH)) i_rec (
        .tbl (tbl_flat),
        .idx (s_q.rec),
        .rec (cur_rec)
    );

    lmap_lane_pack i_pack (
        .lane      (s_q.lane),
        .sw        (nib_sw),
        .pe        (nib_pe),
        .drv_val   (cur_rec.drv_val),
        .pe_val    (cur_rec.pe_val),
        .set_byte  (pk_set),
        .drv_part  (pk_drv),
        .emph_part (pk_emph),
        .mask_part (pk_mask),
        .en_part   (pk_en)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        hit     = (cur_rec.sw_lvl == {6'd0, nib_sw}) &&
                  (cur_rec.pe_lvl == {6'd0, nib_pe});
        nx_set  = s_q.w_set  | ({24'd0, pk_set} << {s_q.lane, 3'b000});
        nx_drv  = s_q.w_drv  | pk_drv;
        nx_emph = s_q.w_emph | pk_emph;
        nx_mask = s_q.w_mask | pk_mask;
        nx_en   = s_q.w_en   | pk_en;

        case (s_q.fsm)
            ST_IDLE: begin
                if (start) begin
                    s_d.err = 1'b0;
                    if (lane_cnt == 3'd0 || lane_cnt > 3'd4) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else begin
                        s_d.fsm    = ST_SEARCH;
                        s_d.lane   = 2'd0;
                        s_d.rec    = 5'd0;
                        s_d.last   = 2'(lane_cnt - 3'd1);
                        s_d.nrec   = (rec_num > DEPTH_L) ? DEPTH_L : rec_num;
                        s_d.adj    = {adj_hi, adj_lo};
                        s_d.w_set  = '0;
                        s_d.w_drv  = '0;
                        s_d.w_emph = '0;
                        s_d.w_mask = '0;
                        s_d.w_auxv = '0;
                        s_d.w_en   = '0;
                    end
                end
            end
            ST_SEARCH: begin
                if (s_q.rec >= s_q.nrec) begin
                    s_d.fsm  = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                end else if (hit) begin
                    s_d.w_set  = nx_set;
                    s_d.w_drv  = nx_drv;
                    s_d.w_emph = nx_emph;
                    s_d.w_mask = nx_mask;
                    s_d.w_en   = nx_en;
                    s_d.w_auxv = cur_rec.aux_val;
                    if (s_q.lane == s_q.last) begin
                        s_d.fsm    = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.o_set  = nx_set;
                        s_d.o_drv  = nx_drv;
                        s_d.o_emph = nx_emph;
                        s_d.o_mask = nx_mask;
                        s_d.o_aux  = {16'd0, cur_rec.aux_val, 4'd0, nx_en};
                    end else begin
                        s_d.lane = s_q.lane + 2'd1;
                        s_d.rec  = 5'd0;
                    end
                end else begin
                    s_d.rec = s_q.rec + 5'd1;
                end
            end
            default: s_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.fsm == ST_SEARCH);
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign lane_set  = s_q.o_set;
    assign drv_word  = s_q.o_drv;
    assign emph_word = s_q.o_emph;
    assign lane_mask = s_q.o_mask;
    assign aux_word  = s_q.o_aux;
    assign aux_mask  = AUX_MSK;
endmodule

// File: rtl/lane_drive_mapper_chk.sv
module lane_drive_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [31:0] lane_set,
    input logic [31:0] drv_word,
    input logic [31:0] lane_mask,
    input logic [31:0] aux_word
);
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9
    AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (lane_set == $past(lane_set) && drv_word == $past(drv_word)
                           && lane_mask == $past(lane_mask) && aux_word == $past(aux_word))); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R8
    AST_OUT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(lane_set) && $stable(aux_word) && $stable(lane_mask))); // R9
    AST_AUX_EN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_word[2] == lane_mask[16] && aux_word[1] == lane_mask[8] &&
         aux_word[0] == lane_mask[0]  && aux_word[3] == lane_mask[24])); // R6
    AST_SWING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        lane_set[2] == (lane_set[1:0] == 2'd3)); // R4
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask[31:24] == 8'd0) |-> (lane_set[31:24] == 8'd0 && drv_word[31:24] == 8'd0)); // R7
endmodule

bind lane_drive_mapper lane_drive_mapper_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .lane_set  (lane_set),
    .drv_word  (drv_word),
    .lane_mask (lane_mask),
    .aux_word  (aux_word)
);

// File: tb/test_lane_drive_mapper.sv
module test_lane_drive_mapper;
    localparam int DEPTH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [7:0]        adj_lo = '0, adj_hi = '0;
    logic [2:0]        lane_cnt = 3'd1;
    logic [4:0]        rec_num = 5'd0;
    logic [DEPTH*40-1:0] tbl_flat = '0;
    logic              busy, done, err;
    logic [31:0]       lane_set, drv_word, emph_word, lane_mask, aux_word, aux_mask;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] tb_rec [DEPTH][5];
    logic [31:0] e_set = '0, e_drv = '0, e_emph = '0, e_mask = '0, e_aux = '0;

    always #10 clk = ~clk;

    lane_drive_mapper #(.REC_DEPTH(DEPTH)) i_lane_drive_mapper (
        .clk(clk), .rst_n(rst_n), .start(start), .adj_lo(adj_lo), .adj_hi(adj_hi),
        .lane_cnt(lane_cnt), .rec_num(rec_num), .tbl_flat(tbl_flat),
        .busy(busy), .done(done), .err(err), .lane_set(lane_set),
        .drv_word(drv_word), .emph_word(emph_word), .lane_mask(lane_mask),
        .aux_word(aux_word), .aux_mask(aux_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_rec(input int r, input int sw, input int pe);
        tb_rec[r][0] = 8'(sw);
        tb_rec[r][1] = 8'(pe);
        tb_rec[r][2] = 8'(8'h10 + r);
        tb_rec[r][3] = 8'(8'h20 + r);
        tb_rec[r][4] = 8'(8'h30 + r);
    endtask

    task automatic load_tbl();
        for (int r = 0; r < DEPTH; r++)
            for (int b = 0; b < 5; b++)
                tbl_flat[r*40 + b*8 +: 8] = tb_rec[r][b];
    endtask

    // Independent model of the requirements
    task automatic model(input logic [15:0] adj, input int nl, input int nr,
                         output bit ok, output int cyc);
        int sh [4] = '{16, 8, 0, 24};
        int nrc;
        logic [31:0] s, d, e, m;
        logic [7:0] av;
        logic [3:0] en;
        ok = 1; cyc = 0; s = '0; d = '0; e = '0; m = '0; av = '0; en = '0;
        nrc = (nr > DEPTH) ? DEPTH : nr;
        if (nl < 1 || nl > 4) begin ok = 0; return; end
        for (int ln = 0; ln < nl; ln++) begin
            int nib, sw, pe, f;
            nib = (adj >> (8*(ln/2) + 4*(ln%2))) & 15;
            sw = nib & 3; pe = nib >> 2; f = -1;
            for (int r = 0; r < nrc; r++)
                if (f < 0 && tb_rec[r][0] == 8'(sw) && tb_rec[r][1] == 8'(pe)) f = r;
            if (f < 0) begin cyc += nrc + 1; ok = 0; return; end
            cyc += f + 1;
            s |= 32'((pe << 3) | sw | ((sw == 3) << 2) | ((pe == 3) << 5)) << (8*ln);
            d |= 32'(tb_rec[f][2]) << sh[ln];
            e |= 32'(tb_rec[f][3]) << sh[ln];
            m |= 32'hFF << sh[ln];
            av = tb_rec[f][4];
            en |= 4'(1 << (sh[ln]/8));
        end
        e_set = s; e_drv = d; e_emph = e; e_mask = m; e_aux = {16'd0, av, 4'd0, en};
    endtask

    task automatic launch(input logic [7:0] lo, input logic [7:0] hi, input int nl, input int nr);
        @(negedge clk);
        adj_lo = lo; adj_hi = hi; lane_cnt = 3'(nl); rec_num = 5'(nr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic check_result(input string req, input bit ok, input int ecyc, input int cyc);
        chk({req, " done"}, 32'(done), 32'd1);
        chk({req, " R10 latency"}, 32'(cyc), 32'(ecyc));
        chk({req, " R8 err"}, 32'(err), 32'(!ok));
        chk({req, " R4 lane_set"}, lane_set, e_set);
        chk({req, " R5 drv_word"}, drv_word, e_drv);
        chk({req, " R5 emph_word"}, emph_word, e_emph);
        chk({req, " R5 lane_mask"}, lane_mask, e_mask);
        chk({req, " R6 aux_word"}, aux_word, e_aux);
    endtask

    task automatic run_case(input string req, input logic [7:0] lo, input logic [7:0] hi,
                            input int nl, input int nr);
        bit ok; int ecyc, cyc;
        model({hi, lo}, nl, nr, ok, ecyc);
        launch(lo, hi, nl, nr);
        wait_done(cyc);
        check_result(req, ok, ecyc, cyc);
        @(negedge clk);
        chk({req, " R9 busy after done"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 lane_set", lane_set, 0);
        chk("R1 drv_word", drv_word, 0);
        chk("R1 emph_word", emph_word, 0);
        chk("R1 lane_mask", lane_mask, 0);
        chk("R1 aux_word", aux_word, 0);
        chk("R1 R6 aux_mask", aux_mask, 32'h0000FF0F);
    endtask

    task automatic t_one_lane();      run_case("R2 R7 one lane", 8'hF0, 8'h33, 1, 8); endtask
    task automatic t_two_lane();      run_case("R2 R5 two lanes", 8'h61, 8'h00, 2, 8); endtask
    task automatic t_four_lane();     run_case("R4 R5 R6 four lanes", 8'hF0, 8'h3E, 4, 15); endtask
    task automatic t_first_match();   run_case("R3 first match", 8'h11, 8'h11, 4, 8); endtask
    task automatic t_rec_limit();     run_case("R3 R8 record limit", 8'h03, 8'h00, 1, 6); endtask
    task automatic t_late_fail();     run_case("R8 fail on lane 2", 8'h10, 8'h05, 4, 8); endtask
    task automatic t_empty_table();   run_case("R8 empty table", 8'h00, 8'h00, 1, 0); endtask
    task automatic t_three_lane();    run_case("R7 three lanes", 8'h62, 8'h08, 3, 8); endtask
    task automatic t_bad_cnt_zero();  run_case("R11 lane count 0", 8'h00, 8'h00, 0, 8); endtask
    task automatic t_bad_cnt_five();  run_case("R11 lane count 5", 8'h00, 8'h00, 5, 8); endtask

    task automatic t_busy_ignore();
        bit ok; int ecyc, cyc, bogus;
        model(16'h8888, 4, 8, ok, ecyc);
        launch(8'h88, 8'h88, 4, 8);
        chk("R9 busy while searching", 32'(busy), 32'd1);
        @(negedge clk);
        adj_lo = 8'h00; adj_hi = 8'h00; lane_cnt = 3'd1; rec_num = 5'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        bogus = cyc + 2;
        check_result("R9 start while busy ignored", ok, ecyc, bogus);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        set_rec(0, 0, 0); set_rec(1, 1, 0); set_rec(2, 2, 1); set_rec(3, 3, 3);
        set_rec(4, 1, 0); set_rec(5, 2, 3); set_rec(6, 3, 0); set_rec(7, 0, 2);
        load_tbl();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_one_lane();
        t_two_lane();
        t_four_lane();
        t_first_match();
        t_rec_limit();
        t_late_fail();
        t_empty_table();
        t_three_lane();
        t_bad_cnt_zero();
        t_bad_cnt_five();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule